// File: doc/BRIEF.md
# Clock-Generator Watchdog with Safe-Code Fallback

This block supervises a programmable clock generator. It chooses the 5-bit frequency-select code that the synthesis logic should apply. The code comes from one of three places: a copy of the strap inputs captured while reset is held, a software-written selection register, or a programmable safe code.

A countdown, paced by a prescaled base tick, measures the time since the last sign of life. A sign of life is either a kick pulse or any configuration write. If the countdown runs out while the watchdog is enabled, the block does not reset anything. Instead it raises a sticky alarm and forces the output code to the safe code. The code stays forced until software clears the alarm.

Configuration uses a simple single-cycle write port that carries three registers: the timeout count, the control word and the software selection. The count and control words can be read back on output buses. The block does not contain the serial bus front end or the frequency synthesiser.

Top module: `clkgen_watchdog`

## Requirements
- R1: After reset the count register reads 16, the control register reads 0x00, the alarm is low and `freq_sel_o` equals the strap code.
- R2: The strap code is taken from `strap_sel_i` on the last cycle with `rst_n` low. Later changes of `strap_sel_i` have no effect on `freq_sel_o`.
- R3: The control word uses this layout: bit 7 is the program enable, bit 6 is the watchdog enable, bit 5 is the alarm, and bits 4:0 are the safe code. With bit 7 set and no alarm, `freq_sel_o` equals bits 4:0 of the selection register (address 2). With bit 7 clear and no alarm, it equals the strap code. The count register is at address 0 and the control register at address 1.
- R4: With the watchdog enabled and count N ≥ 1, the alarm rises exactly N×PRESCALE clock cycles after the last restart.
- R5: A count of 0 times out on the first base tick, which comes PRESCALE cycles after the restart.
- R6: A one-cycle `kick_i` pulse restarts the countdown from the count register.
- R7: Any configuration write, to any address, restarts the countdown. A write to the count register restarts it from the newly written value.
- R8: While the alarm is set, `freq_sel_o` equals the safe code, whatever the program enable says.
- R9: The alarm is sticky. Only a control write with bit 5 = 0 clears it. A control write with bit 5 = 1 neither sets it nor clears it.
- R10: With the watchdog enable at 0, the alarm never rises, however long the block runs.
- R11: After the alarm is cleared by a control write that keeps the watchdog enabled, a full new timeout of N×PRESCALE cycles is needed before the alarm rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap code is sampled while it is low |
| strap_sel_i | input | 5 | Hardware frequency-select straps |
| kick_i | input | 1 | Service pulse that restarts the countdown |
| cfg_wr_i | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr_i | input | 2 | Register address: 0 count, 1 control, 2 software selection |
| cfg_wdata_i | input | 8 | Write data |
| count_o | output | 8 | Count register read-back |
| ctrl_o | output | 8 | Control register read-back, with the live alarm in bit 5 |
| freq_sel_o | output | 5 | Frequency-select code passed to the synthesiser |
| alarm_o | output | 1 | Alarm flag |

## Verification
Some properties are checked by assertions on every cycle:
- The alarm only rises on a base tick.
- A disabled watchdog never raises the alarm.
- A kick pulse never coincides with a new alarm.
- The alarm stays set until a clearing control write.
- The captured strap code never changes after reset.
- Base ticks are never back to back.

Other behaviour can only be shown by the bench's scenarios:
- The exact timeout cycle counts for several values of N, including 0.
- The restart from kicks and from writes.
- The choice of output code in each mode.
- That strap changes after reset are ignored.

// File: rtl/wd_pkg.sv
// Package: shared widths, register addresses and the control-word layout
// for the clock-generator watchdog.
// Assumes: one 8-bit register space of up to four registers.
package wd_pkg;
    localparam int unsigned FSEL_W = 5;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_SWSEL = 2'd2;

    // Control word; field order is the register bit order, MSB first.
    typedef struct packed {
        logic              prog_en;
        logic              wd_en;
        logic              alarm;
        logic [FSEL_W-1:0] safe;
    } ctrl_word_t;
endpackage

// File: rtl/wd_prescaler.sv
// Module: divides the block clock into a one-cycle base tick every
// PRESCALE cycles.
// Assumes: PRESCALE >= 1. A restart or a stopped run puts the phase back
// to zero, so the first tick after a restart comes exactly PRESCALE
// cycles later.
module wd_prescaler #(
    parameter int unsigned PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int unsigned PCW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PCW-1:0] LAST = PCW'(PRESCALE - 1);

    logic [PCW-1:0] phase_q;
    logic           at_last;

    assign at_last = (phase_q == LAST);
    assign tick_o  = run_i && !restart_i && at_last;

    // Advance the phase counter while running; wrap at the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !run_i) begin
            phase_q <= '0;
        end else if (at_last) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    generate
        if (PRESCALE > 1) begin : g_gap_check
            // R4: ticks are spaced by the prescale period, never adjacent
            a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/wd_countdown.sv
// Module: the timeout counter and the sticky alarm flag.
// Assumes: tick_i is a one-cycle pulse. A reload takes priority over a
// tick in the same cycle. A remaining count of 0 or 1 expires on the
// next tick.
module wd_countdown
    import wd_pkg::*;
#(
    parameter int unsigned COUNT_RESET = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic [REG_W-1:0] load_val_i,
    input  logic             alarm_clr_i,
    output logic             alarm_o
);
    logic [REG_W-1:0] remain_q;
    logic             alarm_q;
    logic             expire;

    assign expire  = en_i && tick_i && !reload_i && !alarm_q && (remain_q <= 8'd1);
    assign alarm_o = alarm_q;

    // Track the remaining base periods; hold the reload value while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= REG_W'(COUNT_RESET);
        end else if (reload_i || !en_i) begin
            remain_q <= load_val_i;
        end else if (tick_i && !alarm_q && remain_q > 8'd1) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // Set the alarm on expiry; only an explicit clear removes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
        end else if (expire) begin
            alarm_q <= 1'b1;
        end else if (alarm_clr_i) begin
            alarm_q <= 1'b0;
        end
    end

    // R4: the alarm can only appear on a base tick
    a_r4_alarm_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_q) |-> $past(tick_i));
    // R10: a disabled watchdog never raises the alarm
    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !alarm_q) |=> !alarm_q);
endmodule

// File: rtl/wd_freq_mux.sv
// Module: picks the frequency-select code. The safe code wins while the
// alarm is set. Otherwise the program enable chooses between the software
// selection and the strap code.
// Assumes: all inputs are registered upstream, so the output is glitch-free
// at cycle granularity.
module wd_freq_mux
    import wd_pkg::*;
(
    input  logic              alarm_i,
    input  logic              prog_en_i,
    input  logic [FSEL_W-1:0] safe_i,
    input  logic [FSEL_W-1:0] sw_sel_i,
    input  logic [FSEL_W-1:0] strap_i,
    output logic [FSEL_W-1:0] sel_o
);
    // Priority select: alarm, then the program enable, then the straps.
    always_comb begin
        if (alarm_i) begin
            sel_o = safe_i;
        end else if (prog_en_i) begin
            sel_o = sw_sel_i;
        end else begin
            sel_o = strap_i;
        end
    end
endmodule

// File: rtl/clkgen_watchdog.sv
// Module: top of the clock-generator watchdog. It holds the register bank
// and the strap capture, and connects the prescaler, the countdown and the
// output-code mux.
// Assumes: cfg_wr_i is a single-cycle strobe. Every write and every kick
// restarts the timeout.
module clkgen_watchdog
    import wd_pkg::*;
#(
    parameter int unsigned PRESCALE    = 72_500_000,
    parameter int unsigned COUNT_RESET = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FSEL_W-1:0] strap_sel_i,
    input  logic              kick_i,
    input  logic              cfg_wr_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [REG_W-1:0]  cfg_wdata_i,
    output logic [REG_W-1:0]  count_o,
    output logic [REG_W-1:0]  ctrl_o,
    output logic [FSEL_W-1:0] freq_sel_o,
    output logic              alarm_o
);
    logic [REG_W-1:0]  count_q;
    logic              prog_en_q;
    logic              wd_en_q;
    logic [FSEL_W-1:0] safe_q;
    logic [FSEL_W-1:0] sw_sel_q;
    logic [FSEL_W-1:0] strap_q;
    logic              wr_count, wr_ctrl, wr_swsel;
    logic              restart, alarm_clr, alarm, tick;
    logic [REG_W-1:0]  load_val;
    ctrl_word_t        wdata_ctrl;
    ctrl_word_t        ctrl_view;

    assign wdata_ctrl = ctrl_word_t'(cfg_wdata_i);
    assign wr_count   = cfg_wr_i && (cfg_addr_i == ADDR_COUNT);
    assign wr_ctrl    = cfg_wr_i && (cfg_addr_i == ADDR_CTRL);
    assign wr_swsel   = cfg_wr_i && (cfg_addr_i == ADDR_SWSEL);
    assign restart    = kick_i || cfg_wr_i;
    assign load_val   = wr_count ? cfg_wdata_i : count_q;
    assign alarm_clr  = wr_ctrl && !wdata_ctrl.alarm;

    // Capture the straps while reset is held; freeze them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap_sel_i;
        end
    end

    // Register bank: timeout count, control fields, software selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= REG_W'(COUNT_RESET);
            prog_en_q <= 1'b0;
            wd_en_q   <= 1'b0;
            safe_q    <= '0;
            sw_sel_q  <= '0;
        end else begin
            if (wr_count) begin
                count_q <= cfg_wdata_i;
            end
            if (wr_ctrl) begin
                prog_en_q <= wdata_ctrl.prog_en;
                wd_en_q   <= wdata_ctrl.wd_en;
                safe_q    <= wdata_ctrl.safe;
            end
            if (wr_swsel) begin
                sw_sel_q <= cfg_wdata_i[FSEL_W-1:0];
            end
        end
    end

    wd_prescaler #(.PRESCALE(PRESCALE)) i_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (wd_en_q && !alarm),
        .restart_i (restart),
        .tick_o    (tick)
    );

    wd_countdown #(.COUNT_RESET(COUNT_RESET)) i_countdown (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (wd_en_q),
        .tick_i      (tick),
        .reload_i    (restart),
        .load_val_i  (load_val),
        .alarm_clr_i (alarm_clr),
        .alarm_o     (alarm)
    );

    wd_freq_mux i_freq_mux (
        .alarm_i   (alarm),
        .prog_en_i (prog_en_q),
        .safe_i    (safe_q),
        .sw_sel_i  (sw_sel_q),
        .strap_i   (strap_q),
        .sel_o     (freq_sel_o)
    );

    // Assemble the control read-back with the live alarm flag.
    always_comb begin
        ctrl_view.prog_en = prog_en_q;
        ctrl_view.wd_en   = wd_en_q;
        ctrl_view.alarm   = alarm;
        ctrl_view.safe    = safe_q;
    end

    assign ctrl_o  = REG_W'(ctrl_view);
    assign count_o = count_q;
    assign alarm_o = alarm;

    // R9: the alarm stays set unless a clearing control write arrives
    a_r9_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && !(cfg_wr_i && cfg_addr_i == ADDR_CTRL && !cfg_wdata_i[5])) |=> alarm_o);
    // R6: a kick restarts the count, so no alarm can appear on that edge
    a_r6_kick_no_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> !$rose(alarm_o));
    // R2: the captured strap code never moves once reset has ended
    a_r2_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));
endmodule

// File: tb/test_clkgen_watchdog.sv
// Directed bench for clkgen_watchdog, built with a short prescale period.
module test_clkgen_watchdog;
    localparam int unsigned P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] strap_sel_i = 5'h0B;
    logic       kick_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [1:0] cfg_addr_i = 2'd0;
    logic [7:0] cfg_wdata_i = 8'h00;
    logic [7:0] count_o, ctrl_o;
    logic [4:0] freq_sel_o;
    logic       alarm_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clkgen_watchdog #(.PRESCALE(P), .COUNT_RESET(16)) i_clkgen_watchdog (
        .clk(clk), .rst_n(rst_n), .strap_sel_i(strap_sel_i), .kick_i(kick_i),
        .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
        .count_o(count_o), .ctrl_o(ctrl_o), .freq_sel_o(freq_sel_o), .alarm_o(alarm_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Single-cycle write; returns at the falling edge just after it took effect.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk);
        kick_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        kick_i = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Alarm must still be low after n*P-1 edges and high after n*P.
    task automatic expect_timeout(input string req, input int n);
        int period = (n == 0) ? P : n * P;
        wait_edges(period - 1);
        check(req, {7'd0, alarm_o}, 8'h00);
        wait_edges(1);
        check(req, {7'd0, alarm_o}, 8'h01);
    endtask

    task automatic t_reset();
        check("R1 count", count_o, 8'd16);
        check("R1 ctrl", ctrl_o, 8'h00);
        check("R1 alarm", {7'd0, alarm_o}, 8'h00);
        check("R1 strap", {3'd0, freq_sel_o}, 8'h0B);
    endtask

    task automatic t_strap_ignored();
        strap_sel_i = 5'h14;
        wait_edges(5);
        check("R2 strap frozen", {3'd0, freq_sel_o}, 8'h0B);
    endtask

    task automatic t_prog_select();
        wr(2'd2, 8'h07);
        check("R3 strap kept", {3'd0, freq_sel_o}, 8'h0B);
        wr(2'd1, 8'h80);
        check("R3 sw select", {3'd0, freq_sel_o}, 8'h07);
        wr(2'd1, 8'h00);
        check("R3 back to strap", {3'd0, freq_sel_o}, 8'h0B);
    endtask

    task automatic t_timeout_and_sticky();
        wr(2'd0, 8'd3);
        wr(2'd1, 8'h5A);
        expect_timeout("R4 N=3", 3);
        check("R8 safe code", {3'd0, freq_sel_o}, 8'h1A);
        check("R4 ctrl alarm bit", ctrl_o, 8'h7A);
        wait_edges(20);
        check("R9 still set", {7'd0, alarm_o}, 8'h01);
        wr(2'd1, 8'hFA);
        check("R9 write one keeps", {7'd0, alarm_o}, 8'h01);
        check("R8 safe beats prog", {3'd0, freq_sel_o}, 8'h1A);
        wr(2'd1, 8'h5A);
        check("R9 cleared", {7'd0, alarm_o}, 8'h00);
        check("R9 strap again", {3'd0, freq_sel_o}, 8'h0B);
        expect_timeout("R11 fresh timeout", 3);
        wr(2'd1, 8'h1A);
        check("R9 clear disabled", {7'd0, alarm_o}, 8'h00);
    endtask

    task automatic t_zero_count();
        wr(2'd0, 8'd0);
        wr(2'd1, 8'h45);
        expect_timeout("R5 count zero", 0);
        check("R8 safe 05", {3'd0, freq_sel_o}, 8'h05);
        wr(2'd1, 8'h05);
    endtask

    task automatic t_kick();
        wr(2'd0, 8'd2);
        wr(2'd1, 8'h40);
        wait_edges(6);
        check("R6 before kick", {7'd0, alarm_o}, 8'h00);
        kick();
        expect_timeout("R6 kick restart", 2);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_write_restart();
        wr(2'd1, 8'h40);
        wait_edges(6);
        wr(2'd2, 8'h03);
        expect_timeout("R7 write restart", 2);
        wr(2'd1, 8'h40);
        wait_edges(3);
        wr(2'd0, 8'd1);
        expect_timeout("R7 new count", 1);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_disabled();
        wr(2'd0, 8'd1);
        wait_edges(40);
        check("R10 disabled", {7'd0, alarm_o}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_strap_ignored();
        t_prog_select();
        t_timeout_and_sticky();
        t_zero_count();
        t_kick();
        t_write_restart();
        t_disabled();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule